// File: doc/BRIEF.md
# Command Ring Pointer Engine

This block is the controller side of a host-to-codec command ring. The host stores 32-bit command words in a 256-slot ring through a memory write port. It then moves a write pointer forward through a small register interface. While the run bit is set, the engine reads the slot after its own read pointer and presents that word on a valid/ready output. The read pointer advances only when the downstream side accepts the word. Fetching stops when the read pointer catches up with the write pointer.

The host uses four 16-bit registers: write pointer, read pointer, ring size and control. The read pointer can only be cleared through a two-step handshake. The control run bit keeps reading back as set until any word already fetched has been taken. A power-down input makes both pointer registers read back as all ones. Software treats that value as a sign that the controller is powered down.

Top module: `cmd_ring_engine`

## Requirements
- R1: The ring has 256 slots. Fetching happens only while the size register (address 2, bits 1:0) holds code 2'b10. With any other code, no word is presented.
- R2: Register addresses are 0 for the write pointer (bits 7:0), 1 for the read pointer (bits 7:0, with the reset bit at bit 15), 2 for size and 3 for control (run at bit 0). After reset, all four registers read 0 and cmdValid is low.
- R3: While running with read pointer ≠ write pointer, the engine presents the word stored at slot read pointer + 1 (modulo 256). Words come out in ring order. cmdCodec carries bits 31:28 of the presented word.
- R4: The read pointer increments only in a cycle where cmdValid and cmdReady are both high. While the output is stalled, cmdData and the read pointer stay unchanged.
- R5: A write-pointer write whose value equals the current read pointer is refused and leaves the write pointer unchanged. ringFull is high when write pointer + 1 equals the read pointer.
- R6: Writing the read-pointer register with bit 15 set makes bit 15 read back as 1 from the next clock on.
- R7: Writing the read-pointer register with bit 15 clear clears the read pointer to 0, provided the reset bit is set. The whole register then reads 0 from the next clock on. The same write made when the reset bit is not set has no effect.
- R8: Once the run bit is cleared, no new word is fetched. Control bit 0 keeps reading 1 until a word already presented has been accepted, and then reads 0.
- R9: While pwrDown is high, reads of the write-pointer and read-pointer registers return 16'hFFFF. Other registers read normally.
- R10: The read pointer wraps from 255 to 0. The word at slot 0 follows the word at slot 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrDown | input | 1 | Power-down indication for pointer reads |
| memWrEn | input | 1 | Ring slot write enable |
| memWrAddr | input | 8 | Ring slot index |
| memWrData | input | 32 | Command word to store |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| cmdValid | output | 1 | Fetched command is presented |
| cmdReady | input | 1 | Downstream accepts the command |
| cmdData | output | 32 | Fetched command word |
| cmdCodec | output | 4 | Target codec address of the command |
| ringFull | output | 1 | Ring has no free slot |

## Verification
The hardest state to reach from the ports is a read pointer sitting at 255 with unread work still in the ring. Only then can the wrap to slot 0 and the full condition be seen. The read pointer cannot be loaded directly. So the bench first uses the reset handshake to clear it to 0, and then posts a write pointer of 255, which gives the full condition and tests the refused overrun write. It then streams 255 words to push the read pointer around the ring before posting slot 0. A separate stall with the run bit dropped while a word is pending checks the lagging control readback.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam logic [1:0] ADDR_WPTR = 2'd0;
  localparam logic [1:0] ADDR_RPTR = 2'd1;
  localparam logic [1:0] ADDR_SIZE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam logic [1:0] SIZE_CODE_FULL = 2'b10;
  localparam int         RST_BIT        = 15;

  typedef struct packed {
    logic wpLoad;
    logic rpClear;
    logic fetch;
  } ringStrobe_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [15:0]      regWrData,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             cmdValid,
  output ringStrobe_t      strobe,
  output logic [PTR_W-1:0] wpVal,
  output logic             rstPhase,
  output logic [1:0]       sizeCode,
  output logic             runBusy,
  output logic             ringFull
);
  logic runReq;
  logic wpWrite, rpWrite, sizeWrite, ctrlWrite;

  assign wpWrite   = regWrEn && (regAddr == ADDR_WPTR);
  assign rpWrite   = regWrEn && (regAddr == ADDR_RPTR);
  assign sizeWrite = regWrEn && (regAddr == ADDR_SIZE);
  assign ctrlWrite = regWrEn && (regAddr == ADDR_CTRL);
  assign wpVal     = regWrData[PTR_W-1:0];

  always_comb begin
    strobe.wpLoad  = wpWrite && (wpVal != rdPtr);
    strobe.rpClear = rpWrite && !regWrData[RST_BIT] && rstPhase;
    strobe.fetch   = runReq && (sizeCode == SIZE_CODE_FULL) && !rstPhase &&
                     (rdPtr != wrPtr) && !cmdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstPhase <= 1'b0;
      sizeCode <= '0;
      runReq   <= 1'b0;
    end else begin
      if (rpWrite && regWrData[RST_BIT]) rstPhase <= 1'b1;
      else if (rpWrite && rstPhase)      rstPhase <= 1'b0;
      if (sizeWrite) sizeCode <= regWrData[1:0];
      if (ctrlWrite) runReq   <= regWrData[0];
    end
  end

  assign runBusy  = runReq || cmdValid;
  assign ringFull = ((wrPtr + PTR_W'(1)) == rdPtr);

  p_ack_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    rpWrite && regWrData[RST_BIT] |=> rstPhase);

  p_refuse_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    wpWrite && (wpVal == rdPtr) |=> wrPtr == $past(wrPtr));

  p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !runReq && !cmdValid |=> !cmdValid);
endmodule

// File: rtl/ring_dp.sv
module ring_dp
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [PTR_W-1:0]  wpVal,
  input  logic              memWrEn,
  input  logic [PTR_W-1:0]  memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  input  logic              cmdReady,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdData
);
  localparam int ENTRIES = 1 << PTR_W;

  logic [DATA_W-1:0] ringMem [ENTRIES];
  logic              handshake;
  logic [PTR_W-1:0]  nextSlot;

  assign handshake = cmdValid && cmdReady;
  assign nextSlot  = rdPtr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (memWrEn) ringMem[memWrAddr] <= memWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      cmdValid <= 1'b0;
      cmdData  <= '0;
    end else begin
      if (strobe.wpLoad) wrPtr <= wpVal;
      if (strobe.rpClear)  rdPtr <= '0;
      else if (handshake)  rdPtr <= nextSlot;
      if (strobe.rpClear)   cmdValid <= 1'b0;
      else if (strobe.fetch) cmdValid <= 1'b1;
      else if (handshake)    cmdValid <= 1'b0;
      if (strobe.fetch) cmdData <= ringMem[nextSlot];
    end
  end

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady && !strobe.rpClear |=>
      cmdValid && $stable(cmdData) && $stable(rdPtr));

  p_rp_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !handshake && !strobe.rpClear |=> $stable(rdPtr));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rpClear |=> rdPtr == '0);
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32,
  parameter int CODEC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDown,
  input  logic              memWrEn,
  input  logic [PTR_W-1:0]  memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [DATA_W-1:0] cmdData,
  output logic [CODEC_W-1:0] cmdCodec,
  output logic              ringFull
);
  ringStrobe_t      strobe;
  logic [PTR_W-1:0] wpVal, wrPtr, rdPtr;
  logic             rstPhase, runBusy;
  logic [1:0]       sizeCode;

  ring_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .wrPtr(wrPtr), .rdPtr(rdPtr), .cmdValid(cmdValid),
    .strobe(strobe), .wpVal(wpVal), .rstPhase(rstPhase), .sizeCode(sizeCode),
    .runBusy(runBusy), .ringFull(ringFull)
  );

  ring_dp #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wpVal(wpVal),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .cmdReady(cmdReady), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .cmdValid(cmdValid), .cmdData(cmdData)
  );

  assign cmdCodec = cmdData[DATA_W-1 -: CODEC_W];

  always_comb begin
    unique case (regAddr)
      ADDR_WPTR: regRdData = pwrDown ? 16'hFFFF : 16'(wrPtr);
      ADDR_RPTR: regRdData = pwrDown ? 16'hFFFF : {rstPhase, 15'(rdPtr)};
      ADDR_SIZE: regRdData = 16'(sizeCode);
      default:   regRdData = 16'(runBusy);
    endcase
  end

  p_pwrdown_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown && (regAddr == ADDR_WPTR || regAddr == ADDR_RPTR) |->
      regRdData == 16'hFFFF);

  p_fetch_needs_size_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(sizeCode) == SIZE_CODE_FULL);
endmodule

// File: tb/cmd_ring_engine_tb.sv
module cmd_ring_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrDown = 1'b0;
  logic        memWrEn = 1'b0;
  logic [7:0]  memWrAddr = '0;
  logic [31:0] memWrData = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdData;
  logic [3:0]  cmdCodec;
  logic        ringFull;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ring_engine u_dut (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .cmdCodec(cmdCodec), .ringFull(ringFull)
  );

  function automatic logic [31:0] pat(int i);
    logic [7:0] b = 8'(i);
    return {b[3:0], 4'h5, 8'hC3, ~b, b};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic memWrite(int a, logic [31:0] d);
    memWrAddr = 8'(a); memWrData = d; memWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic waitValid(int limit);
    for (int w = 0; w < limit && !cmdValid; w++) @(negedge clk);
  endtask

  task automatic collect(int n, int startIdx, string req);
    for (int k = 0; k < n; k++) begin
      int idx = (startIdx + k) % 256;
      waitValid(20);
      check(cmdValid == 1'b1, req, 32'(cmdValid), 32'd1);
      check(cmdData == pat(idx), req, cmdData, pat(idx));
      check(cmdCodec == 4'(idx), req, 32'(cmdCodec), 32'(idx[3:0]));
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), d);
      check(d == 16'h0, "R2", 32'(d), 32'h0);
    end
    check(cmdValid == 1'b0, "R2", 32'(cmdValid), 32'h0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    for (int i = 1; i <= 3; i++) memWrite(i, pat(i));
    regWrite(2'd2, 16'h0002);
    regWrite(2'd0, 16'd3);
    cmdReady = 1'b1;
    regWrite(2'd3, 16'h0001);
    collect(3, 1, "R3");
    regRead(2'd1, d);
    check(d == 16'd3, "R4", 32'(d), 32'd3);
    check(cmdValid == 1'b0, "R3", 32'(cmdValid), 32'd0);
  endtask

  task automatic t_stall();
    logic [15:0] d;
    logic [31:0] held;
    cmdReady = 1'b0;
    memWrite(4, pat(4));
    regWrite(2'd0, 16'd4);
    waitValid(20);
    held = cmdData;
    check(held == pat(4), "R4", held, pat(4));
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(cmdValid && cmdData == held, "R4", cmdData, held);
      regRead(2'd1, d);
      check(d == 16'd3, "R4", 32'(d), 32'd3);
    end
    cmdReady = 1'b1;
    @(posedge clk); @(negedge clk);
    regRead(2'd1, d);
    check(d == 16'd4, "R4", 32'(d), 32'd4);
  endtask

  task automatic t_runstop();
    logic [15:0] d;
    cmdReady = 1'b0;
    memWrite(5, pat(5));
    regWrite(2'd0, 16'd5);
    waitValid(20);
    regWrite(2'd3, 16'h0000);
    regRead(2'd3, d);
    check(d == 16'd1, "R8", 32'(d), 32'd1);
    cmdReady = 1'b1;
    @(posedge clk); @(negedge clk);
    cmdReady = 1'b0;
    regRead(2'd3, d);
    check(d == 16'd0, "R8", 32'(d), 32'd0);
    memWrite(6, pat(6));
    regWrite(2'd0, 16'd6);
    repeat (6) @(negedge clk);
    check(cmdValid == 1'b0, "R8", 32'(cmdValid), 32'd0);
    regRead(2'd1, d);
    check(d == 16'd5, "R8", 32'(d), 32'd5);
  endtask

  task automatic t_rptrReset();
    logic [15:0] d;
    regWrite(2'd1, 16'h0000);
    regRead(2'd1, d);
    check(d == 16'd5, "R7", 32'(d), 32'd5);
    regWrite(2'd1, 16'h8000);
    regRead(2'd1, d);
    check(d == 16'h8005, "R6", 32'(d), 32'h8005);
    regWrite(2'd1, 16'h0000);
    regRead(2'd1, d);
    check(d == 16'h0000, "R7", 32'(d), 32'h0);
  endtask

  task automatic t_full();
    logic [15:0] d;
    regWrite(2'd0, 16'd255);
    check(ringFull == 1'b1, "R5", 32'(ringFull), 32'd1);
    regWrite(2'd0, 16'd0);
    regRead(2'd0, d);
    check(d == 16'd255, "R5", 32'(d), 32'd255);
    check(ringFull == 1'b1, "R5", 32'(ringFull), 32'd1);
  endtask

  task automatic t_size();
    regWrite(2'd2, 16'h0000);
    regWrite(2'd3, 16'h0001);
    repeat (6) @(negedge clk);
    check(cmdValid == 1'b0, "R1", 32'(cmdValid), 32'd0);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    for (int i = 0; i < 256; i++) memWrite(i, pat(i));
    cmdReady = 1'b1;
    regWrite(2'd2, 16'h0002);
    collect(255, 1, "R10");
    regRead(2'd1, d);
    check(d == 16'd255, "R10", 32'(d), 32'd255);
    regWrite(2'd0, 16'd0);
    collect(1, 0, "R10");
    regRead(2'd1, d);
    check(d == 16'd0, "R10", 32'(d), 32'd0);
  endtask

  task automatic t_pwrDown();
    logic [15:0] d;
    pwrDown = 1'b1;
    regRead(2'd0, d);
    check(d == 16'hFFFF, "R9", 32'(d), 32'hFFFF);
    regRead(2'd1, d);
    check(d == 16'hFFFF, "R9", 32'(d), 32'hFFFF);
    regRead(2'd2, d);
    check(d == 16'h0002, "R9", 32'(d), 32'h2);
    pwrDown = 1'b0;
    regRead(2'd0, d);
    check(d == 16'h0000, "R9", 32'(d), 32'h0);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_runstop();
    t_rptrReset();
    t_full();
    t_size();
    t_wrap();
    t_pwrDown();
    finish();
  end
endmodule